// File: doc/BRIEF.md
# Automatic Xoff/Xon Transmit Generator

This block sits between a UART's transmit data queue and its serializer. It watches the receive FIFO fill count. When the count rises to a programmed trigger level and stays there for two character times, the block inserts an Xoff into the transmit stream. After that, when the count has drained to the next lower level, it inserts an Xon. Each flow-control message is either one character or a pair of characters sent back to back.

The serializer marks each character boundary with a ready handshake. A flow-control character waits for that boundary and then goes ahead of any queued data. Normal data passes straight through whenever no flow-control message is being sent. One character-time tick from the baud generator sets the Xoff delay. The block does nothing on its own unless automatic flow control is enabled.

Top module: `fc_xmit_gen`

## Requirements
- R1: After reset, the block is in the released (Xon) state and presents no flow-control character. With `data_valid_i` low, `tx_valid_o` is 0, and a FIFO count of 0 does not cause an Xon.
- R2: `trig_sel_i` selects the Xoff threshold, and an Xoff is armed when the FIFO count is at or above it. The encodings are 0 for 8, 1 for 16, 2 for 24 and 3 for 28. A count one below the threshold never causes an Xoff.
- R3: Once the count is at or above the threshold, the Xoff is presented only after two `char_tick_i` pulses have been counted. It is not presented after only one.
- R4: If the count falls below the threshold before the second tick, the pending Xoff is cancelled. A later crossing needs two fresh ticks.
- R5: While the block is in the stopped state, an Xon is presented when the count is at or below the lower level for the selected trigger. The lower levels are 0 for trigger 8, 8 for 16, 16 for 24 and 24 for 28. A count one above the lower level causes no Xon.
- R6: With `dual_char_i` = 1, the second character (`xoff2_i` or `xon2_i`) follows the first (`xoff1_i` or `xon1_i`) at the next boundary. With `dual_char_i` = 0, only the first character is sent.
- R7: Xoff and Xon alternate. After an Xoff completes, no further Xoff is sent while the count stays high. An Xon is sent only in the stopped state.
- R8: While `auto_en_i` = 0, no flow-control sequence starts and the Xoff delay is cleared.
- R9: A flow-control character stays on `tx_data_o` with `tx_valid_o` high until `tx_ready_i` accepts it. `data_ready_o` is 0 for the whole sequence.
- R10: When no sequence is active, `tx_valid_o` and `tx_data_o` follow `data_valid_i` and `data_i`, and `data_ready_o` follows `tx_ready_i`. A due flow-control character replaces the queued data at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| auto_en_i | input | 1 | Enable for automatic flow control |
| dual_char_i | input | 1 | 1 = two-character messages |
| trig_sel_i | input | 2 | Trigger level select |
| fifo_cnt_i | input | CNT_W | Receive FIFO fill count |
| xoff1_i | input | CHAR_W | First Xoff character |
| xoff2_i | input | CHAR_W | Second Xoff character |
| xon1_i | input | CHAR_W | First Xon character |
| xon2_i | input | CHAR_W | Second Xon character |
| char_tick_i | input | 1 | One pulse per character time |
| data_valid_i | input | 1 | Queued data character valid |
| data_i | input | CHAR_W | Queued data character |
| data_ready_o | output | 1 | Queued data character taken |
| tx_ready_i | input | 1 | Serializer accepts a character (boundary) |
| tx_valid_o | output | 1 | Character presented to the serializer |
| tx_data_o | output | CHAR_W | Character to the serializer |

## Verification
The assertions check four behaviours on every cycle. A presented flow-control character is held stable until it is accepted. The Xoff delay can expire only on a tick and only while armed. The stopped state changes only when a sequence of the matching kind completes. Nothing starts while the block is disabled. The bench scenarios cover the rest. They show the threshold and lower-level values for each trigger setting, the exact tick count before an Xoff, cancellation and restart of the delay, the order of the two characters, and data being displaced at a boundary. None of these can be seen by looking at a single cycle.

// File: rtl/fc_gen_pkg.sv
package fc_gen_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_SECOND} seq_st_e;
  typedef enum logic {FC_XON = 1'b0, FC_XOFF = 1'b1} fc_kind_e;
  localparam int NUM_TRIG = 4;
endpackage

// File: rtl/fc_level_cmp.sv
module fc_level_cmp
  import fc_gen_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int LVL0  = 8,
  parameter int LVL1  = 16,
  parameter int LVL2  = 24,
  parameter int LVL3  = 28
) (
  input  logic [1:0]       trig_sel_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             at_hi_o,
  output logic             at_lo_o
);
  localparam int LVL [NUM_TRIG] = '{LVL0, LVL1, LVL2, LVL3};

  logic [CNT_W-1:0] hi_tab [NUM_TRIG];
  logic [CNT_W-1:0] lo_tab [NUM_TRIG];

  // Xon level is the next lower trigger; the lowest trigger releases at zero
  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_lvl
    assign hi_tab[g] = CNT_W'(LVL[g]);
    if (g == 0) begin : g_base
      assign lo_tab[g] = '0;
    end else begin : g_step
      assign lo_tab[g] = CNT_W'(LVL[g-1]);
    end
  end

  assign at_hi_o = cnt_i >= hi_tab[trig_sel_i];
  assign at_lo_o = cnt_i <= lo_tab[trig_sel_i];
endmodule

// File: rtl/fc_delay.sv
module fc_delay #(
  parameter int DELAY_CHARS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic tick_i,
  output logic due_o
);
  localparam int CW = $clog2(DELAY_CHARS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DELAY_CHARS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (!arm_i)                    cnt_q <= '0;
    else if (tick_i && cnt_q != LIMIT)  cnt_q <= cnt_q + 1'b1;
  end

  assign due_o = cnt_q == LIMIT;

  // R3
  due_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(due_o) |-> $past(tick_i));
  // R4
  due_needs_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> !due_o);
endmodule

// File: rtl/fc_seq.sv
module fc_seq
  import fc_gen_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     dual_i,
  input  logic     at_hi_i,
  input  logic     at_lo_i,
  input  logic     due_i,
  input  logic     tx_ready_i,
  output logic     arm_o,
  output logic     fc_valid_o,
  output logic     second_o,
  output fc_kind_e kind_o
);
  seq_st_e  st_q;
  fc_kind_e kind_q;
  logic     dual_q, stopped_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      kind_q    <= FC_XON;
      dual_q    <= 1'b0;
      stopped_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (en_i) begin
          if (!stopped_q && due_i) begin
            st_q   <= ST_FIRST;
            kind_q <= FC_XOFF;
            dual_q <= dual_i;
          end else if (stopped_q && at_lo_i) begin
            st_q   <= ST_FIRST;
            kind_q <= FC_XON;
            dual_q <= dual_i;
          end
        end
        ST_FIRST: if (tx_ready_i) begin
          if (dual_q) st_q <= ST_SECOND;
          else begin
            st_q      <= ST_IDLE;
            stopped_q <= kind_q == FC_XOFF;
          end
        end
        ST_SECOND: if (tx_ready_i) begin
          st_q      <= ST_IDLE;
          stopped_q <= kind_q == FC_XOFF;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign arm_o      = en_i && !stopped_q && at_hi_i && st_q == ST_IDLE;
  assign fc_valid_o = st_q != ST_IDLE;
  assign second_o   = st_q == ST_SECOND;
  assign kind_o     = kind_q;

  // R7
  stop_after_xoff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stopped_q) |-> $past(kind_q == FC_XOFF && tx_ready_i));
  // R7
  release_after_xon_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stopped_q) |-> $past(kind_q == FC_XON && tx_ready_i));
  // R8
  idle_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !en_i) |=> st_q == ST_IDLE);
endmodule

// File: rtl/fc_xmit_gen.sv
module fc_xmit_gen
  import fc_gen_pkg::*;
#(
  parameter int CNT_W       = 6,
  parameter int CHAR_W      = 8,
  parameter int DELAY_CHARS = 2,
  parameter int LVL0        = 8,
  parameter int LVL1        = 16,
  parameter int LVL2        = 24,
  parameter int LVL3        = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              auto_en_i,
  input  logic              dual_char_i,
  input  logic [1:0]        trig_sel_i,
  input  logic [CNT_W-1:0]  fifo_cnt_i,
  input  logic [CHAR_W-1:0] xoff1_i,
  input  logic [CHAR_W-1:0] xoff2_i,
  input  logic [CHAR_W-1:0] xon1_i,
  input  logic [CHAR_W-1:0] xon2_i,
  input  logic              char_tick_i,
  input  logic              data_valid_i,
  input  logic [CHAR_W-1:0] data_i,
  output logic              data_ready_o,
  input  logic              tx_ready_i,
  output logic              tx_valid_o,
  output logic [CHAR_W-1:0] tx_data_o
);
  logic     at_hi, at_lo, arm, due, fc_valid, second;
  fc_kind_e kind;
  logic [CHAR_W-1:0] fc_char;

  fc_level_cmp #(
    .CNT_W(CNT_W), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)
  ) u_cmp (
    .trig_sel_i(trig_sel_i), .cnt_i(fifo_cnt_i), .at_hi_o(at_hi), .at_lo_o(at_lo)
  );

  fc_delay #(.DELAY_CHARS(DELAY_CHARS)) u_delay (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm), .tick_i(char_tick_i), .due_o(due)
  );

  fc_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(auto_en_i), .dual_i(dual_char_i),
    .at_hi_i(at_hi), .at_lo_i(at_lo), .due_i(due), .tx_ready_i(tx_ready_i),
    .arm_o(arm), .fc_valid_o(fc_valid), .second_o(second), .kind_o(kind)
  );

  always_comb begin
    if (kind == FC_XOFF) fc_char = second ? xoff2_i : xoff1_i;
    else                 fc_char = second ? xon2_i  : xon1_i;
  end

  // flow-control characters pre-empt queued data at a boundary
  assign tx_valid_o   = fc_valid || data_valid_i;
  assign tx_data_o    = fc_valid ? fc_char : data_i;
  assign data_ready_o = !fc_valid && tx_ready_i;

  // R9
  fc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fc_valid && !tx_ready_i) |=> (tx_valid_o && !data_ready_o));
endmodule

// File: tb/tb_fc_xmit_gen.sv
module tb_fc_xmit_gen;
  localparam logic [7:0] XOFF1 = 8'h13, XOFF2 = 8'hA5, XON1 = 8'h11, XON2 = 8'h5A;

  typedef struct packed {
    logic [1:0] trig;
    logic [5:0] hi;
    logic [5:0] lo;
    logic       dual;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 6'd8,  6'd0,  1'b0}, '{2'd1, 6'd16, 6'd8,  1'b0},
    '{2'd2, 6'd24, 6'd16, 1'b0}, '{2'd3, 6'd28, 6'd24, 1'b0},
    '{2'd0, 6'd8,  6'd0,  1'b1}, '{2'd1, 6'd16, 6'd8,  1'b1},
    '{2'd2, 6'd24, 6'd16, 1'b1}, '{2'd3, 6'd28, 6'd24, 1'b1}
  };

  logic clk = 0, rst_ni = 0;
  logic auto_en = 0, dual = 0, tick = 0, dvalid = 0, tx_ready = 0;
  logic [1:0] trig = 0;
  logic [5:0] cnt = 0;
  logic [7:0] din = 0;
  logic dready, tx_valid;
  logic [7:0] tx_data;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fc_xmit_gen dut (
    .clk_i(clk), .rst_ni(rst_ni), .auto_en_i(auto_en), .dual_char_i(dual),
    .trig_sel_i(trig), .fifo_cnt_i(cnt), .xoff1_i(XOFF1), .xoff2_i(XOFF2),
    .xon1_i(XON1), .xon2_i(XON2), .char_tick_i(tick), .data_valid_i(dvalid),
    .data_i(din), .data_ready_o(dready), .tx_ready_i(tx_ready),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0; auto_en = 0; dual = 0; tick = 0; dvalid = 0; tx_ready = 0; cnt = 0; trig = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
  endtask

  task automatic do_tick();
    tick = 1; @(negedge clk); tick = 0;
  endtask

  task automatic accept();
    tx_ready = 1; @(negedge clk); tx_ready = 0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    chk(!tx_valid, "R1 idle after reset", tx_valid, 0);
    chk(!dready, "R1 no ready after reset", dready, 0);
    auto_en = 1; trig = 2'd0; cnt = 0;
    wait_n(4);
    chk(!tx_valid, "R1 no Xon at count 0 when released", tx_valid, 0);

    // table walk: R2 R3 R5 R6
    for (int i = 0; i < NV; i++) begin
      do_reset();
      auto_en = 1; trig = VECS[i].trig; dual = VECS[i].dual;
      cnt = VECS[i].hi - 1;
      do_tick(); do_tick(); do_tick(); wait_n(2);
      chk(!tx_valid, "R2 below threshold", tx_valid, 0);
      cnt = VECS[i].hi;
      do_tick(); wait_n(2);
      chk(!tx_valid, "R3 one tick only", tx_valid, 0);
      do_tick(); wait_n(2);
      chk(tx_valid && tx_data == XOFF1, "R2 R3 Xoff1 presented", {tx_valid, tx_data}, {1'b1, XOFF1});
      accept();
      if (VECS[i].dual) begin
        chk(tx_valid && tx_data == XOFF2, "R6 Xoff2 follows", {tx_valid, tx_data}, {1'b1, XOFF2});
        accept();
      end
      chk(!tx_valid, "R6 Xoff sequence length", tx_valid, 0);
      cnt = VECS[i].lo + 1;
      wait_n(3);
      chk(!tx_valid, "R5 above lower level", tx_valid, 0);
      cnt = VECS[i].lo;
      wait_n(2);
      chk(tx_valid && tx_data == XON1, "R5 Xon1 presented", {tx_valid, tx_data}, {1'b1, XON1});
      accept();
      if (VECS[i].dual) begin
        chk(tx_valid && tx_data == XON2, "R6 Xon2 follows", {tx_valid, tx_data}, {1'b1, XON2});
        accept();
      end
      chk(!tx_valid, "R6 Xon sequence length", tx_valid, 0);
    end

    // R4 cancel and restart
    do_reset();
    auto_en = 1; trig = 2'd1; cnt = 16;
    do_tick(); cnt = 15; wait_n(2); cnt = 16;
    do_tick(); wait_n(2);
    chk(!tx_valid, "R4 delay restarted after dip", tx_valid, 0);
    do_tick(); wait_n(2);
    chk(tx_valid && tx_data == XOFF1, "R4 Xoff after fresh two ticks", tx_data, XOFF1);

    // R9 hold until accepted
    wait_n(5);
    chk(tx_valid && tx_data == XOFF1, "R9 held without ready", tx_data, XOFF1);
    accept();

    // R7 no repeated Xoff while stopped
    cnt = 20;
    do_tick(); do_tick(); do_tick(); wait_n(2);
    chk(!tx_valid, "R7 no second Xoff", tx_valid, 0);

    // R8 disabled
    do_reset();
    auto_en = 0; trig = 2'd3; cnt = 30;
    do_tick(); do_tick(); do_tick(); wait_n(2);
    chk(!tx_valid, "R8 nothing while disabled", tx_valid, 0);
    auto_en = 1;
    do_tick(); wait_n(2);
    chk(!tx_valid, "R8 delay cleared while disabled", tx_valid, 0);
    do_tick(); wait_n(2);
    chk(tx_valid && tx_data == XOFF1, "R8 Xoff after enable", tx_data, XOFF1);

    // R10 pass-through and pre-emption
    do_reset();
    auto_en = 1; trig = 2'd0; dvalid = 1; din = 8'h41;
    wait_n(1);
    chk(tx_valid && tx_data == 8'h41, "R10 data passes", tx_data, 8'h41);
    tx_ready = 1; #1;
    chk(dready, "R10 ready follows", dready, 1);
    @(negedge clk); tx_ready = 0;
    cnt = 9;
    do_tick(); do_tick(); wait_n(2);
    chk(tx_valid && tx_data == XOFF1, "R10 Xoff replaces data", tx_data, XOFF1);
    tx_ready = 1; #1;
    chk(!dready, "R9 data not taken during sequence", dready, 0);
    @(negedge clk); tx_ready = 0;
    chk(tx_valid && tx_data == 8'h41, "R10 data resumes", tx_data, 8'h41);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule